// File: doc/BRIEF.md
# Hotplug Slot Status Register Bank

This block keeps track of device insertion and removal requests for 32 slots on each of several buses and lets firmware see and act on them through a small 32-bit register window. Two device-side report inputs carry a bus index and a slot number. A plug report sets the slot's bit in that bus's insertion mask. A removal request sets the bit in the removal mask. Either report produces a one-cycle firmware event pulse. Firmware first writes a bus number into the select register. Every per-bus register then refers to that bus. Firmware reads the pending masks and writes a slot mask to the eject register, which produces an eject command carrying the bus and slot.

A platform reset pulse (`plat_reset`) starts a drain sequence. The drain walks the buses in ascending order and ejects every pending removal, lowest slot first, one per clock. It then reloads each bus's removable mask from the per-bus non-hotpluggable input. The drain also runs once after power-on reset. A busy output stays high for the whole sequence, and register writes are ignored while it is high. A legacy-mode input keeps the insertion mask after a read and pins the bus select to zero.

The drain controller has three named states. SCAN ejects from or steps past the current bus. LOAD latches the removable masks. IDLE waits for a platform reset. The transitions are:
- SCAN→SCAN, when a removal is pending (eject) or a later bus remains (advance).
- SCAN→LOAD, on the last bus once it is empty.
- LOAD→IDLE, unconditionally.
- IDLE→SCAN, on a platform reset, restarting at bus 0.

Top module: `hp_slot_regs`

## Requirements
- R1: Register offsets, byte addresses, aligned 32-bit accesses only:
  - 0x00 is the insertion mask.
  - 0x04 is the removal mask.
  - 0x08 is the eject register, which always reads 0.
  - 0x0C is the removable mask.
  - 0x10 is the bus select.
  - Any other address reads 0.
  - Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled.
  - Slot n is bit n of each mask.
- R2: A plug report sets the slot's bit in that bus's insertion mask. A removal report sets the bit in that bus's removal mask. Either report raises `fw_event` for exactly one cycle, in the cycle after the report.
- R3: Outside legacy mode, a read of the insertion mask clears it for the selected bus. In legacy mode the mask is kept.
- R4: An eject write with non-zero data takes the lowest set bit as the slot. It clears that bit in both masks of the selected bus and issues one eject command (`eject_vld`, `eject_bus`, `eject_slot`) in the next cycle. A zero write does nothing.
- R5: When the select register holds a value at or above NUM_BUS, every read returns 0 and eject writes are ignored.
- R6: A select write stores the written value, or 0 when legacy mode is high.
- R7: A plug or removal report in the same cycle as a clearing read or an eject of the same bit leaves the bit set.
- R8: A platform reset ejects every pending removal, buses in ascending order and slots lowest first, one command per consecutive cycle while a bus has pending bits.
- R9: `busy` is high from the cycle after the platform reset until the drain ends. Register writes are ignored while it is high.
- R10: At the end of each drain, each bus's removable mask becomes the inverse of that bus's 32-bit field of `nohp_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| plat_reset | input | 1 | Platform reset pulse that starts the drain |
| legacy_mode | input | 1 | Keeps insertion mask on read, pins select to 0 |
| reg_addr | input | 5 | Byte address in the register window |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| plug_vld | input | 1 | Device plugged report |
| plug_bus | input | BW | Bus of the plug report |
| plug_slot | input | 5 | Slot of the plug report |
| unplug_vld | input | 1 | Removal request report |
| unplug_bus | input | BW | Bus of the removal request |
| unplug_slot | input | 5 | Slot of the removal request |
| nohp_mask | input | NUM_BUS*32 | Non-hotpluggable slots, 32 bits per bus, bus 0 lowest |
| fw_event | output | 1 | One-cycle firmware event |
| eject_vld | output | 1 | Eject command valid |
| eject_bus | output | BW | Bus of the eject command |
| eject_slot | output | 5 | Slot of the eject command |
| busy | output | 1 | Drain in progress |

## Verification
The main function is tried with single-slot reports on different buses, two removals on one bus ejected by a multi-bit mask, zero and out-of-range ejects, and reports that collide with a clearing read. A multi-bit eject mask separates lowest-bit selection from any other choice. Repeated reads separate clear-on-read from legacy retention. The drain is started with removals pending on non-adjacent buses and on two slots of one bus. This checks the ascending bus order, the lowest-slot-first order and the back-to-back timing. A select write and an eject write made during the drain show that writes are blocked while busy.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int SLOTS  = 32;
    localparam int SLOT_W = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_INS = 5'h00,
        OFS_REM = 5'h04,
        OFS_EJ  = 5'h08,
        OFS_RMV = 5'h0C,
        OFS_SEL = 5'h10
    } reg_ofs_e;

    typedef enum logic [1:0] {
        ST_SCAN = 2'd0,
        ST_LOAD = 2'd1,
        ST_IDLE = 2'd2
    } drain_st_e;

    // index of the lowest set bit, 0 for an empty mask
    function automatic logic [SLOT_W-1:0] lowest_slot(input logic [SLOTS-1:0] m);
        lowest_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (m[i]) lowest_slot = SLOT_W'(i);
        end
    endfunction
endpackage

// File: rtl/hp_bus_bank.sv
module hp_bus_bank
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOTS-1:0]  set_ins,
    input  logic [SLOTS-1:0]  set_rem,
    input  logic [SLOTS-1:0]  clr_ins,
    input  logic [SLOTS-1:0]  clr_rem,
    input  logic              load_rmv,
    input  logic [SLOTS-1:0]  nohp,
    output logic [SLOTS-1:0]  ins_q,
    output logic [SLOTS-1:0]  rem_q,
    output logic [SLOTS-1:0]  rmv_q
);
    // set terms are applied after clear terms: a fresh report wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ins_q <= '0;
            rem_q <= '0;
            rmv_q <= '1;
        end else begin
            ins_q <= (ins_q & ~clr_ins) | set_ins;
            rem_q <= (rem_q & ~clr_rem) | set_rem;
            if (load_rmv) rmv_q <= ~nohp;
        end
    end
endmodule

// File: rtl/hp_drain_fsm.sv
module hp_drain_fsm
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4,
    parameter int BW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SLOTS-1:0]  cur_rem,
    output logic              busy,
    output logic [BW-1:0]     cur_bus,
    output logic              drain_ej,
    output logic [SLOT_W-1:0] drain_slot,
    output logic              load_rmv
);
    localparam logic [BW-1:0] LAST_BUS = BW'(NUM_BUS - 1);

    drain_st_e     state_q, state_d;
    logic [BW-1:0] bus_q, bus_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            bus_q   <= '0;
        end else begin
            state_q <= state_d;
            bus_q   <= bus_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        bus_d   = bus_q;
        unique case (state_q)
            ST_SCAN: begin
                if (cur_rem == '0) begin
                    if (bus_q == LAST_BUS) state_d = ST_LOAD;
                    else                   bus_d   = bus_q + 1'b1;
                end
            end
            ST_LOAD: state_d = ST_IDLE;
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SCAN;
                    bus_d   = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        cur_bus    = bus_q;
        drain_ej   = (state_q == ST_SCAN) && (cur_rem != '0);
        drain_slot = lowest_slot(cur_rem);
        load_rmv   = (state_q == ST_LOAD);
    end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4,
    localparam int BW     = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     plat_reset,
    input  logic                     legacy_mode,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_rd,
    input  logic                     reg_wr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic                     plug_vld,
    input  logic [BW-1:0]            plug_bus,
    input  logic [SLOT_W-1:0]        plug_slot,
    input  logic                     unplug_vld,
    input  logic [BW-1:0]            unplug_bus,
    input  logic [SLOT_W-1:0]        unplug_slot,
    input  logic [NUM_BUS*SLOTS-1:0] nohp_mask,
    output logic                     fw_event,
    output logic                     eject_vld,
    output logic [BW-1:0]            eject_bus,
    output logic [SLOT_W-1:0]        eject_slot,
    output logic                     busy
);
    localparam logic [31:0] NB32 = 32'(NUM_BUS);

    logic [DATA_W-1:0]                 sel_q;
    logic [NUM_BUS-1:0][SLOTS-1:0]     ins_all, rem_all, rmv_all;
    logic                              sel_ok;
    logic [BW-1:0]                     sel_idx;
    logic                              plug_ok, unplug_ok;
    logic                              rd_clr, wr_ej, act_ej;
    logic [BW-1:0]                     act_bus;
    logic [SLOT_W-1:0]                 act_slot;
    logic [BW-1:0]                     cur_bus;
    logic                              drain_ej, load_rmv;
    logic [SLOT_W-1:0]                 drain_slot;
    logic [DATA_W-1:0]                 rd_val;

    assign sel_ok    = (sel_q < NB32);
    assign sel_idx   = sel_q[BW-1:0];
    assign plug_ok   = plug_vld   && (32'(plug_bus)   < NB32);
    assign unplug_ok = unplug_vld && (32'(unplug_bus) < NB32);
    assign rd_clr    = reg_rd && (reg_addr == OFS_INS) && sel_ok && !legacy_mode;
    assign wr_ej     = reg_wr && (reg_addr == OFS_EJ) && sel_ok && !busy
                       && (reg_wdata != '0);
    assign act_ej    = drain_ej || wr_ej;
    assign act_bus   = drain_ej ? cur_bus : sel_idx;
    assign act_slot  = drain_ej ? drain_slot : lowest_slot(reg_wdata);

    hp_drain_fsm #(.NUM_BUS(NUM_BUS), .BW(BW)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (plat_reset),
        .cur_rem    (rem_all[cur_bus]),
        .busy       (busy),
        .cur_bus    (cur_bus),
        .drain_ej   (drain_ej),
        .drain_slot (drain_slot),
        .load_rmv   (load_rmv)
    );

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        logic [SLOTS-1:0] set_ins, set_rem, clr_ej, clr_ins;
        assign set_ins = (plug_ok && plug_bus == BW'(b))
                         ? (SLOTS'(1) << plug_slot) : '0;
        assign set_rem = (unplug_ok && unplug_bus == BW'(b))
                         ? (SLOTS'(1) << unplug_slot) : '0;
        assign clr_ej  = (act_ej && act_bus == BW'(b))
                         ? (SLOTS'(1) << act_slot) : '0;
        assign clr_ins = clr_ej | ((rd_clr && sel_idx == BW'(b)) ? '1 : '0);

        hp_bus_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_ins  (set_ins),
            .set_rem  (set_rem),
            .clr_ins  (clr_ins),
            .clr_rem  (clr_ej),
            .load_rmv (load_rmv),
            .nohp     (nohp_mask[b*SLOTS +: SLOTS]),
            .ins_q    (ins_all[b]),
            .rem_q    (rem_all[b]),
            .rmv_q    (rmv_all[b])
        );
    end

    // read multiplexer
    always_comb begin
        rd_val = '0;
        if (sel_ok) begin
            unique case (reg_addr)
                OFS_INS: rd_val = ins_all[sel_idx];
                OFS_REM: rd_val = rem_all[sel_idx];
                OFS_RMV: rd_val = rmv_all[sel_idx];
                OFS_SEL: rd_val = sel_q;
                default: rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= '0;
            reg_rdata  <= '0;
            fw_event   <= 1'b0;
            eject_vld  <= 1'b0;
            eject_bus  <= '0;
            eject_slot <= '0;
        end else begin
            if (reg_wr && reg_addr == OFS_SEL && !busy)
                sel_q <= legacy_mode ? '0 : reg_wdata;
            if (reg_rd) reg_rdata <= rd_val;
            fw_event  <= plug_ok || unplug_ok;
            eject_vld <= act_ej;
            if (act_ej) begin
                eject_bus  <= act_bus;
                eject_slot <= act_slot;
            end
        end
    end
endmodule

// File: rtl/hp_slot_regs_chk.sv
module hp_slot_regs_chk
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4,
    parameter int BW      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              legacy_mode,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              plug_vld,
    input logic [BW-1:0]     plug_bus,
    input logic              unplug_vld,
    input logic [BW-1:0]     unplug_bus,
    input logic              fw_event,
    input logic              eject_vld,
    input logic [BW-1:0]     eject_bus,
    input logic              busy,
    input logic [DATA_W-1:0] sel_q
);
    localparam logic [31:0] NB32 = 32'(NUM_BUS);

    a_r2_event_follows_report: assert property (@(posedge clk) disable iff (!rst_n)
        ((plug_vld && 32'(plug_bus) < NB32) || (unplug_vld && 32'(unplug_bus) < NB32))
        |=> fw_event);

    a_r2_event_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_event && !plug_vld && !unplug_vld) |=> !fw_event);

    a_r1_eject_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 5'h08) |=> (reg_rdata == '0));

    a_r5_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel_q >= NB32) |=> (reg_rdata == '0));

    a_r4_write_ejects: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 5'h08 && !busy && sel_q < NB32 && reg_wdata != '0)
        |=> (eject_vld && eject_bus == $past(sel_q[BW-1:0])));

    a_r6_legacy_select_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_mode && reg_wr && reg_addr == 5'h10 && !busy) |=> (sel_q == '0));

    a_r9_select_blocked_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 5'h10) |=> $stable(sel_q));

    a_r8_eject_bus_range: assert property (@(posedge clk) disable iff (!rst_n)
        eject_vld |-> (32'(eject_bus) < NB32));
endmodule

bind hp_slot_regs hp_slot_regs_chk #(.NUM_BUS(NUM_BUS), .BW(BW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .legacy_mode (legacy_mode),
    .reg_addr    (reg_addr),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .plug_vld    (plug_vld),
    .plug_bus    (plug_bus),
    .unplug_vld  (unplug_vld),
    .unplug_bus  (unplug_bus),
    .fw_event    (fw_event),
    .eject_vld   (eject_vld),
    .eject_bus   (eject_bus),
    .busy        (busy),
    .sel_q       (sel_q)
);

// File: tb/tb_hp_slot_regs.sv
`timescale 1ns/1ps
module tb_hp_slot_regs;
    localparam int NB = 4;
    localparam int BW = 2;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              plat_reset = 0;
    logic              legacy_mode = 0;
    logic [4:0]        reg_addr = '0;
    logic              reg_rd = 0, reg_wr = 0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              plug_vld = 0, unplug_vld = 0;
    logic [BW-1:0]     plug_bus = '0, unplug_bus = '0;
    logic [4:0]        plug_slot = '0, unplug_slot = '0;
    logic [NB*32-1:0]  nohp_mask = '0;
    logic              fw_event, eject_vld, busy;
    logic [BW-1:0]     eject_bus;
    logic [4:0]        eject_slot;

    int checks = 0, fails = 0;
    int q_bus[$];
    int q_slot[$];

    always #4 clk = ~clk;

    hp_slot_regs #(.NUM_BUS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .plat_reset(plat_reset), .legacy_mode(legacy_mode),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .plug_vld(plug_vld), .plug_bus(plug_bus),
        .plug_slot(plug_slot), .unplug_vld(unplug_vld), .unplug_bus(unplug_bus),
        .unplug_slot(unplug_slot), .nohp_mask(nohp_mask), .fw_event(fw_event),
        .eject_vld(eject_vld), .eject_bus(eject_bus), .eject_slot(eject_slot), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // scoreboard monitor for eject commands
    always @(posedge clk) begin
        #1;
        if (rst_n && eject_vld) begin
            if (q_bus.size() == 0) begin
                checks++; fails++;
                $display("FAIL R4/R9: unexpected eject actual bus %0d slot %0d expected none",
                         eject_bus, eject_slot);
            end else begin
                check("R4 R8 eject bus", 32'(eject_bus), 32'(q_bus.pop_front()));
                check("R4 R8 eject slot", 32'(eject_slot), 32'(q_slot.pop_front()));
            end
        end
    end

    task automatic expect_ej(input int b, input int s);
        q_bus.push_back(b);
        q_slot.push_back(s);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1;
        @(posedge clk); #1; d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk); #1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic report_dev(input bit is_plug, input int b, input int s);
        @(negedge clk);
        if (is_plug) begin plug_vld = 1; plug_bus = BW'(b); plug_slot = 5'(s); end
        else begin unplug_vld = 1; unplug_bus = BW'(b); unplug_slot = 5'(s); end
        @(posedge clk); #1; check("R2 event pulse", 32'(fw_event), 1);
        @(negedge clk); plug_vld = 0; unplug_vld = 0;
        @(posedge clk); #1; check("R2 event single cycle", 32'(fw_event), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [31:0] d;
        #1;
        check("R1 reset rdata", reg_rdata, 0);
        check("R2 reset event", 32'(fw_event), 0);
        check("R4 reset eject", 32'(eject_vld), 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        while (busy) @(posedge clk);
        #1;
        rd(5'h0C, d); check("R10 removable after power-on", d, 32'hFFFF_FFFF);
        rd(5'h10, d); check("R1 select reset value", d, 0);
        rd(5'h14, d); check("R1 unmapped offset", d, 0);

        // R2, R3: plug on bus 1, clear-on-read
        report_dev(1, 1, 5);
        wr(5'h10, 1);
        rd(5'h10, d); check("R6 select stored", d, 1);
        rd(5'h00, d); check("R2 insertion bit", d, 32'h20);
        rd(5'h00, d); check("R3 cleared on read", d, 0);

        // R7: plug collides with clearing read
        report_dev(1, 1, 6);
        @(negedge clk); reg_addr = 5'h00; reg_rd = 1;
        plug_vld = 1; plug_bus = 1; plug_slot = 6;
        @(posedge clk); #1; d = reg_rdata;
        check("R7 read during report", d, 32'h40);
        @(negedge clk); reg_rd = 0; plug_vld = 0;
        rd(5'h00, d); check("R7 report wins over clear", d, 32'h40);
        rd(5'h00, d); check("R3 cleared after second read", d, 0);

        // R4: removals on bus 2, multi-bit eject mask
        report_dev(0, 2, 7);
        report_dev(0, 2, 9);
        report_dev(1, 2, 7);
        wr(5'h10, 2);
        rd(5'h04, d); check("R2 removal mask", d, 32'h280);
        expect_ej(2, 7);
        wr(5'h08, 32'h280);
        rd(5'h04, d); check("R4 removal bit cleared", d, 32'h200);
        rd(5'h00, d); check("R4 insertion bit cleared", d, 0);
        wr(5'h08, 0);
        rd(5'h04, d); check("R4 zero eject ignored", d, 32'h200);
        rd(5'h08, d); check("R1 eject reads zero", d, 0);

        // R7: removal collides with eject of same bit (bus 2 slot 9)
        expect_ej(2, 9);
        @(negedge clk); reg_addr = 5'h08; reg_wdata = 32'h200; reg_wr = 1;
        unplug_vld = 1; unplug_bus = 2; unplug_slot = 9;
        @(posedge clk); #1;
        @(negedge clk); reg_wr = 0; unplug_vld = 0;
        rd(5'h04, d); check("R7 removal wins over eject", d, 32'h200);

        // R5: out-of-range select
        report_dev(1, 3, 4);
        wr(5'h10, 7);
        rd(5'h10, d); check("R5 select read zero", d, 0);
        rd(5'h0C, d); check("R5 removable read zero", d, 0);
        wr(5'h08, 32'h1);
        wr(5'h10, 3);
        rd(5'h00, d); check("R5 eject ignored", d, 32'h10);

        // R8, R9, R10: drain
        report_dev(0, 0, 30);
        report_dev(0, 0, 2);
        report_dev(0, 3, 1);
        nohp_mask[3*32 +: 32] = 32'h0000_00F0;
        expect_ej(0, 2); expect_ej(0, 30); expect_ej(2, 9); expect_ej(3, 1);
        @(negedge clk); plat_reset = 1;
        @(posedge clk); #1; check("R9 busy after platform reset", 32'(busy), 1);
        @(negedge clk); plat_reset = 0;
        @(posedge clk); #1;
        check("R8 first eject", 32'(eject_vld), 1);
        check("R8 lowest slot first", 32'(eject_slot), 2);
        @(posedge clk); #1;
        check("R8 back-to-back eject", 32'(eject_vld), 1);
        check("R8 second slot", 32'(eject_slot), 30);
        wr(5'h10, 0);
        wr(5'h08, 32'h1);
        while (busy) @(posedge clk);
        #1;
        check("R8 scoreboard drained", 32'(q_bus.size()), 0);
        rd(5'h10, d); check("R9 select write blocked", d, 3);
        rd(5'h04, d); check("R8 removals cleared", d, 0);
        rd(5'h0C, d); check("R10 removable reloaded", d, 32'hFFFF_FF0F);

        // R3, R6: legacy mode
        report_dev(1, 0, 3);
        legacy_mode = 1;
        wr(5'h10, 2);
        rd(5'h10, d); check("R6 legacy select forced", d, 0);
        rd(5'h00, d); check("R3 legacy first read", d, 32'h8);
        rd(5'h00, d); check("R3 legacy kept", d, 32'h8);
        legacy_mode = 0;
        rd(5'h00, d); check("R3 normal read", d, 32'h8);
        rd(5'h00, d); check("R3 normal cleared", d, 0);

        repeat (3) @(posedge clk);
        #2;
        check("R4 no leftover ejects", 32'(q_bus.size()), 0);
        report();
        $finish;
    end
endmodule